// File: doc/BRIEF.md
# Group-Bypass Binary Adder

This block adds two unsigned N-bit operands and a single carry-in bit. It produces an N-bit sum and a carry-out. It is purely combinational: there is no clock, no reset and no register anywhere in the datapath. The operand width is a parameter with a default of 16 bits, and it must be a whole multiple of four.

The operands are cut into four-bit slices. Inside a slice the carry ripples from bit to bit. Each slice also carries a skip path. When every bit of the slice would pass an incoming carry straight through, a multiplexer hands the slice's incoming carry directly to the next slice and bypasses the internal ripple. When any bit of the slice kills or generates, the rippled value is used instead, and in that case the rippled value no longer depends on the incoming carry.

The longest carry path therefore crosses the first and last slices bit by bit and jumps over each slice in between with a single multiplexer. The adder is meant to sit between registers elsewhere in a datapath, wherever a wide add must close timing without a full lookahead tree.

Top module: `csk_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i`, all three taken as unsigned values.
- R2: `cout_o` equals bit WIDTH of `a_i + b_i + cin_i`, that is, the carry out of the most significant position.
- R3: When `a_i` is the bitwise complement of `b_i` (every bit propagates), `cout_o` equals `cin_i`. In that case `sum_o` is all ones when `cin_i` is 0, and all zeros when `cin_i` is 1.
- R4: A four-bit slice whose bit pairs all differ (A XOR B = 4'b1111 in that slice) forwards its incoming carry unchanged to the next slice. So a carry born in a lower slice reaches the slices above it, and the passed-through slice reads 4'b0000 in `sum_o`.
- R5: A slice in which some bit pair is equal produces a carry-out that does not depend on its incoming carry. The carry-out is 1 if the highest equal pair in the slice is 1/1, and 0 if that pair is 0/0.
- R6: The all-ones operands with `cin_i` of 0 and of 1 give a sum of all ones except bit 0 equal to `cin_i`, with `cout_o` = 1. Zero operands with `cin_i` = 0 give all-zero outputs.
- R7: WIDTH is a parameter with a default of 16. A WIDTH that is not a multiple of 4 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Low WIDTH bits of the total |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
Suppose a slice's skip multiplexer picks the wrong source, or its internal ripple takes a wrong term. That error is visible at the ports in the same evaluation as the input change. A skip fault only shows when a whole slice propagates and a carry actually arrives at it. For that reason the directed cases build such slices on purpose: a lower slice generates and the slices above it pass the carry on. A fault inside the ripple shows in the sum bits of its own slice, and in every slice above when it corrupts the carry leaving that slice.

// File: rtl/csk_pkg.sv
package csk_pkg;

    // Number of bits covered by one ripple slice and its skip multiplexer.
    localparam int unsigned GROUP_W = 4;

    // Per-slice propagate / generate bundle.
    typedef struct packed {
        logic [GROUP_W-1:0] prop;
        logic [GROUP_W-1:0] gen;
    } slice_pg_t;

    // Combinational state of one slice.
    typedef struct packed {
        logic [GROUP_W:0]   chain;   // chain[0] = incoming carry, chain[k+1] = carry out of bit k
        logic               skip;    // every bit of the slice propagates
        logic               carry;   // carry handed to the next slice
        logic [GROUP_W-1:0] sum;
    } slice_res_t;

endpackage

// File: rtl/csk_pg_gen.sv
module csk_pg_gen
    import csk_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] prop_o,
    output logic [WIDTH-1:0] gen_o
);

    logic [WIDTH-1:0] prop_d;
    logic [WIDTH-1:0] gen_d;

    // Bit k passes a carry when exactly one operand bit is set,
    // and creates one when both are set.
    always_comb begin
        prop_d = a_i ^ b_i;
        gen_d  = a_i & b_i;
    end

    assign prop_o = prop_d;
    assign gen_o  = gen_d;

endmodule

// File: rtl/csk_group.sv
module csk_group
    import csk_pkg::*;
(
    input  slice_pg_t          pg_i,
    input  logic               cin_i,
    output logic [GROUP_W-1:0] sum_o,
    output logic               cout_o
);

    slice_res_t res_d;

    always_comb begin
        res_d          = '0;
        res_d.chain[0] = cin_i;
        for (int k = 0; k < GROUP_W; k++) begin
            res_d.chain[k+1] = pg_i.gen[k] | (pg_i.prop[k] & res_d.chain[k]);
        end
        res_d.skip  = &pg_i.prop;
        res_d.sum   = pg_i.prop ^ res_d.chain[GROUP_W-1:0];
        res_d.carry = res_d.skip ? cin_i : res_d.chain[GROUP_W];
    end

    assign sum_o  = res_d.sum;
    assign cout_o = res_d.carry;

    // Reference ripple started with the carry forced low, used only by the checks.
    logic [GROUP_W:0] chain_zero;
    always_comb begin
        chain_zero[0] = 1'b0;
        for (int k = 0; k < GROUP_W; k++) begin
            chain_zero[k+1] = pg_i.gen[k] | (pg_i.prop[k] & chain_zero[k]);
        end
    end

    always_comb begin
        // R4
        group_skip_chk: assert (!res_d.skip || (res_d.chain[GROUP_W] == cin_i))
            else $error("skip taken but ripple disagrees with incoming carry");
        // R5
        group_nodep_chk: assert (res_d.skip || (cout_o == chain_zero[GROUP_W]))
            else $error("non-skipping slice carry depends on incoming carry");
        // R1
        group_sum_chk: assert ({cout_o, sum_o} ==
                               ({1'b0, pg_i.prop} + {pg_i.gen, 1'b0} + {{GROUP_W{1'b0}}, cin_i}))
            else $error("slice total differs from operand arithmetic");
    end

endmodule

// File: rtl/csk_adder.sv
module csk_adder
    import csk_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int unsigned NUM_SLICES = WIDTH / GROUP_W;

    // R7: width must fill whole slices
    if ((WIDTH % GROUP_W) != 0 || WIDTH == 0) begin : g_width_bad
        $error("csk_adder: WIDTH must be a nonzero multiple of the slice width");
    end

    logic [WIDTH-1:0]      prop_w;
    logic [WIDTH-1:0]      gen_w;
    logic [NUM_SLICES:0]   slice_carry;
    logic [WIDTH-1:0]      sum_d;

    csk_pg_gen #(.WIDTH(WIDTH)) u_pg (
        .a_i    (a_i),
        .b_i    (b_i),
        .prop_o (prop_w),
        .gen_o  (gen_w)
    );

    assign slice_carry[0] = cin_i;

    for (genvar si = 0; si < NUM_SLICES; si++) begin : g_slice
        slice_pg_t pg_s;
        always_comb begin
            pg_s.prop = prop_w[si*GROUP_W +: GROUP_W];
            pg_s.gen  = gen_w[si*GROUP_W +: GROUP_W];
        end

        csk_group u_grp (
            .pg_i   (pg_s),
            .cin_i  (slice_carry[si]),
            .sum_o  (sum_d[si*GROUP_W +: GROUP_W]),
            .cout_o (slice_carry[si+1])
        );
    end

    assign sum_o  = sum_d;
    assign cout_o = slice_carry[NUM_SLICES];

    always_comb begin
        // R2
        adder_total_chk: assert ({cout_o, sum_o} ==
                                 ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
            else $error("adder total differs from operand arithmetic");
        // R3
        adder_allprop_chk: assert (((a_i ^ b_i) != {WIDTH{1'b1}}) ||
                                   ((cout_o == cin_i) && (sum_o == {WIDTH{~cin_i}})))
            else $error("all-propagate operands gave wrong result");
    end

endmodule

// File: tb/tb_csk_adder.sv
module tb_csk_adder;

    localparam int unsigned W = 16;

    logic         clk = 1'b0;
    logic [W-1:0] a, b, sum;
    logic         cin, cout;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    bit          done   = 1'b0;

    always #5 clk = ~clk;

    csk_adder #(.WIDTH(W)) dut (
        .a_i    (a),
        .b_i    (b),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                         input logic cv, input string req);
        logic [W:0] exp;
        @(posedge clk);
        a = av; b = bv; cin = cv;
        exp = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
        @(negedge clk);
        checks++;
        if (sum !== exp[W-1:0] || cout !== exp[W]) begin
            fails++;
            $display("FAIL %s: a=%h b=%h cin=%0d got sum=%h cout=%0d expected sum=%h cout=%0d",
                     req, av, bv, cv, sum, cout, exp[W-1:0], exp[W]);
        end
    endtask

    task automatic expect_out(input logic [W-1:0] es, input logic ec, input string req);
        checks++;
        if (sum !== es || cout !== ec) begin
            fails++;
            $display("FAIL %s: got sum=%h cout=%0d expected sum=%h cout=%0d",
                     req, sum, cout, es, ec);
        end
    endtask

    // R6: zero operands right after start
    task automatic t_zero();
        apply('0, '0, 1'b0, "R6 zero");
        expect_out(16'h0000, 1'b0, "R6 zero explicit");
    endtask

    // R3: every bit propagates
    task automatic t_all_prop();
        apply(16'hA5C3, 16'h5A3C, 1'b0, "R3 prop cin0");
        expect_out(16'hFFFF, 1'b0, "R3 prop cin0 explicit");
        apply(16'hA5C3, 16'h5A3C, 1'b1, "R3 prop cin1");
        expect_out(16'h0000, 1'b1, "R3 prop cin1 explicit");
        apply(16'h0000, 16'hFFFF, 1'b1, "R3 zero/ones cin1");
    endtask

    // R6: all-ones operands
    task automatic t_all_ones();
        apply(16'hFFFF, 16'hFFFF, 1'b0, "R6 ones cin0");
        expect_out(16'hFFFE, 1'b1, "R6 ones cin0 explicit");
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R6 ones cin1");
        expect_out(16'hFFFF, 1'b1, "R6 ones cin1 explicit");
    endtask

    // R4: carry born in slice 0 skips over propagating slices above
    task automatic t_skip();
        apply(16'h00F8, 16'h0008, 1'b0, "R4 skip one slice");
        expect_out(16'h0100, 1'b0, "R4 skip one slice explicit");
        apply(16'hFFF8, 16'h0008, 1'b0, "R4 skip to top");
        expect_out(16'h0000, 1'b1, "R4 skip to top explicit");
        apply(16'h0F0F, 16'h00F1, 1'b0, "R4 skip middle");
    endtask

    // R5: generating / killing slices ignore incoming carry
    task automatic t_gen_kill();
        apply(16'h0080, 16'h0080, 1'b0, "R5 generate cin0");
        apply(16'h0080, 16'h0080, 1'b1, "R5 generate cin1");
        apply(16'h0F7F, 16'h0001, 1'b0, "R5 kill in slice1");
        expect_out(16'h0F80, 1'b0, "R5 kill explicit");
        apply(16'h8000, 16'h8000, 1'b1, "R5 top generate");
        expect_out(16'h0001, 1'b1, "R5 top generate explicit");
    endtask

    // R1 R2: random operands
    task automatic t_random();
        for (int i = 0; i < 3000; i++) begin
            apply(W'($urandom), W'($urandom), 1'($urandom), "R1 R2 random");
        end
    endtask

    // R7: default width of 16 seen at the ports
    task automatic t_width();
        apply(16'h8000, 16'h7FFF, 1'b1, "R7 width16");
        expect_out(16'h0000, 1'b1, "R7 width16 explicit");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        t_zero();
        t_all_prop();
        t_all_ones();
        t_skip();
        t_gen_kill();
        t_width();
        t_random();
        finish_run();
    end

    initial begin
        #(1_000_000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

endmodule